// File: doc/BRIEF.md
# Software Interrupt Distributor

This block routes software-raised interrupts between up to eight processor interfaces. A processor raises an interrupt with a single bus write that carries an interrupt number and a routing choice. The routing choice is one of three: an explicit list of CPUs, every CPU except the writer, or the writer alone. The distributor marks the number pending on each selected CPU and records which CPU raised it. Each CPU sees one interrupt-request line.

A CPU takes an interrupt with an acknowledge read. The read returns the lowest-numbered interrupt that is pending and not already in service, tagged with the number of the CPU that raised it. The interrupt then moves from pending to active. The CPU finishes it by writing the acknowledged number to an end-of-interrupt operation. It can also clear active state directly with a write-1-to-clear mask. While an interrupt is active on a CPU, a fresh raise of the same number stays pending and is not signalled until the active state is removed.

All accesses use one shared bus. The bus carries an operation code, the acting CPU number and a 32-bit write word. Acknowledge data comes back one cycle after the acknowledge operation.

Top module: `sgi_distributor`

## Requirements
- R1: A raise (bus_op=1) with filter bits [25:24]=0 targets every CPU c whose bit c is set in bits [23:16]; bits naming CPUs at or above NCPU are ignored.
- R2: A raise with filter 2 targets only the writing CPU (bus_cpu).
- R3: A raise with filter 1 targets every CPU except the writing CPU.
- R4: A raise with filter 3 changes no state and no request line.
- R5: A raise sets interrupt number bits [3:0] pending on each target and stores bus_cpu as its source; a later raise of the same number on the same target overwrites the stored source.
- R6: An acknowledge (bus_op=2) by CPU c selects the lowest number that is pending and not active on c. In the next cycle rd_valid is 1 and rd_data holds the number in [9:0], the source in [12:10] and zeros elsewhere. The selected interrupt leaves pending and becomes active.
- R7: An acknowledge with nothing eligible returns 1023 in [9:0] with all other bits zero and changes no state.
- R8: An end-of-interrupt (bus_op=3) by CPU c with [9:0] equal to a number below 16 clears that number's active state on c; larger values have no effect.
- R9: A clear-active write (bus_op=4) by CPU c clears active state of every number n whose bit n in [15:0] is 1, on c only.
- R10: irq[c] is 1 exactly when CPU c has some number pending and not active; a number raised while active on c does not assert irq[c].
- R11: After reset all pending and active state is clear, irq is all zero, rd_valid is 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_op | input | 3 | 0 idle, 1 raise, 2 acknowledge, 3 end-of-interrupt, 4 clear-active |
| bus_cpu | input | 3 | Number of the CPU performing the operation |
| bus_wdata | input | 32 | Write word for raise, end-of-interrupt and clear-active |
| rd_data | output | 32 | Acknowledge result |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's acknowledge |
| irq | output | NCPU | Interrupt request per CPU |

## Verification
The assertions assume that only one operation is presented per cycle and that bus_cpu names an implemented CPU whenever bus_op is not idle. The stimulus issues one operation at a time from a single task and draws writer numbers only from the configured CPU range. It sweeps every writer against every filter value. After each sweep step it drains every CPU through acknowledges until the spurious value appears, and compares each result and each request line against an arithmetic model of pending, active and source state.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int          ID_W     = 10;
    localparam int          SRC_W    = 3;
    localparam int          NUM_SGI  = 16;
    localparam int          SGI_W    = $clog2(NUM_SGI);
    localparam logic [ID_W-1:0] SPURIOUS = 10'd1023;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_RAISE  = 3'd1,
        OP_ACK    = 3'd2,
        OP_EOI    = 3'd3,
        OP_CLRACT = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {
        RT_LIST   = 2'd0,
        RT_OTHERS = 2'd1,
        RT_SELF   = 2'd2,
        RT_NONE   = 2'd3
    } route_e;

    typedef struct packed {
        route_e           route;
        logic [7:0]       list;
        logic [SGI_W-1:0] num;
    } raise_t;

    function automatic raise_t unpack_raise(input logic [31:0] w);
        raise_t r;
        r.route = route_e'(w[25:24]);
        r.list  = w[23:16];
        r.num   = w[SGI_W-1:0];
        return r;
    endfunction

    function automatic logic [31:0] pack_ack(input logic [SRC_W-1:0] src,
                                             input logic [ID_W-1:0] id);
        return {{(32-SRC_W-ID_W){1'b0}}, src, id};
    endfunction

endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic            valid,
    input  raise_t          req,
    input  logic [2:0]      writer,
    output logic [NCPU-1:0] targets
);
    for (genvar c = 0; c < NCPU; c++) begin : g_tgt
        always_comb begin
            unique case (req.route)
                RT_LIST:   targets[c] = valid & req.list[c];
                RT_OTHERS: targets[c] = valid & (writer != 3'(c));
                RT_SELF:   targets[c] = valid & (writer == 3'(c));
                default:   targets[c] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sgi_cpu_bank.sv
module sgi_cpu_bank
    import sgi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               raise,
    input  logic [SGI_W-1:0]   raise_num,
    input  logic [SRC_W-1:0]   raise_src,
    input  logic               ack,
    input  logic               eoi,
    input  logic [ID_W-1:0]    eoi_id,
    input  logic               clr,
    input  logic [NUM_SGI-1:0] clr_mask,
    output logic               irq,
    output logic [31:0]        ack_word
);
    logic [NUM_SGI-1:0] pend, act, elig;
    logic [SRC_W-1:0]   src [NUM_SGI];
    logic [SGI_W-1:0]   sel;
    logic               any;

    assign elig = pend & ~act;
    assign irq  = any;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NUM_SGI - 1; i >= 0; i--) begin
            if (elig[i]) begin
                sel = SGI_W'(i);
                any = 1'b1;
            end
        end
    end

    assign ack_word = any ? pack_ack(src[sel], ID_W'(sel)) : pack_ack('0, SPURIOUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            act  <= '0;
            for (int i = 0; i < NUM_SGI; i++) src[i] <= '0;
        end else begin
            if (raise) begin
                pend[raise_num] <= 1'b1;
                src[raise_num]  <= raise_src;
            end
            if (ack && any) begin
                pend[sel] <= 1'b0;
                act[sel]  <= 1'b1;
            end
            if (eoi && (eoi_id < ID_W'(NUM_SGI)))
                act[eoi_id[SGI_W-1:0]] <= 1'b0;
            if (clr)
                act <= act & ~clr_mask;
        end
    end

    AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        (ack && any) |=> (act[$past(sel)] && !pend[$past(sel)])); // R6
    AST_EOI_ENDS: assert property (@(posedge clk) disable iff (rst)
        (eoi && eoi_id < ID_W'(NUM_SGI)) |=> !act[$past(eoi_id[SGI_W-1:0])]); // R8
    AST_CLR_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((act & $past(clr_mask)) == '0)); // R9
    AST_ACK_EMPTY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ack && !any && !raise && !eoi && !clr) |=> ($stable(pend) && $stable(act))); // R7
endmodule

// File: rtl/sgi_distributor.sv
module sgi_distributor
    import sgi_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      bus_op,
    input  logic [2:0]      bus_cpu,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     rd_data,
    output logic            rd_valid,
    output logic [NCPU-1:0] irq
);
    bus_op_e         op;
    raise_t          req;
    logic [NCPU-1:0] targets;
    logic [31:0]     words [NCPU];
    logic [31:0]     sel_word;

    assign op  = bus_op_e'(bus_op);
    assign req = unpack_raise(bus_wdata);

    sgi_target_decode #(.NCPU(NCPU)) u_dec (
        .valid   (op == OP_RAISE),
        .req     (req),
        .writer  (bus_cpu),
        .targets (targets)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic me;
        assign me = (bus_cpu == 3'(c));
        sgi_cpu_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .raise     (targets[c]),
            .raise_num (req.num),
            .raise_src (bus_cpu),
            .ack       (me && op == OP_ACK),
            .eoi       (me && op == OP_EOI),
            .eoi_id    (bus_wdata[ID_W-1:0]),
            .clr       (me && op == OP_CLRACT),
            .clr_mask  (bus_wdata[NUM_SGI-1:0]),
            .irq       (irq[c]),
            .ack_word  (words[c])
        );
    end

    always_comb begin
        sel_word = pack_ack('0, SPURIOUS);
        for (int c = 0; c < NCPU; c++)
            if (bus_cpu == 3'(c)) sel_word = words[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (op == OP_ACK);
            if (op == OP_ACK) rd_data <= sel_word;
        end
    end

    AST_SPURIOUS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_data[ID_W-1:0] == SPURIOUS) |-> (rd_data[31:ID_W] == '0)); // R7
    AST_ROUTE_NONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RAISE && req.route == RT_NONE) |=> $stable(irq)); // R4
    AST_RDVALID_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(bus_op) == 3'(OP_ACK))); // R6
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RAISE && req.route == RT_SELF) |-> ((targets & ~(NCPU'(1) << bus_cpu)) == '0)); // R2
endmodule

// File: tb/sim_sgi_distributor.sv
module sim_sgi_distributor;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op  = '0;
    logic [2:0]    cpu = '0;
    logic [31:0]   wd  = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [NC-1:0] irq;

    int checks = 0;
    int fails  = 0;
    int last_ack = 0;
    bit done = 0;

    bit mp [NC][16];
    bit ma [NC][16];
    int ms [NC][16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_distributor #(.NCPU(NC)) u0 (
        .clk(clk), .rst(rst), .bus_op(op), .bus_cpu(cpu), .bus_wdata(wd),
        .rd_data(rdata), .rd_valid(rvalid), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] model_irq();
        logic [NC-1:0] r = '0;
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < 16; i++)
                if (mp[c][i] && !ma[c][i]) r[c] = 1'b1;
        return r;
    endfunction

    task automatic do_op(input int o, input int c, input logic [31:0] d, input string tag);
        logic [31:0] exp = 32'd1023;
        @(negedge clk);
        op = 3'(o); cpu = 3'(c); wd = d;
        case (o)
            1: begin
                for (int t = 0; t < NC; t++) begin
                    bit hit;
                    case (d[25:24])
                        2'd0: hit = d[16+t];
                        2'd1: hit = (t != c);
                        2'd2: hit = (t == c);
                        default: hit = 0;
                    endcase
                    if (hit) begin
                        mp[t][d[3:0]] = 1;
                        ms[t][d[3:0]] = c;
                    end
                end
            end
            2: begin
                for (int i = 15; i >= 0; i--)
                    if (mp[c][i] && !ma[c][i]) exp = 32'(i) | (32'(ms[c][i]) << 10);
                if (exp != 32'd1023) begin
                    mp[c][exp[3:0]] = 0;
                    ma[c][exp[3:0]] = 1;
                end
            end
            3: if (d[9:0] < 16) ma[c][d[3:0]] = 0;
            4: for (int i = 0; i < 16; i++) if (d[i]) ma[c][i] = 0;
            default: ;
        endcase
        @(negedge clk);
        op = '0;
        if (o == 2) begin
            check(32'(rvalid), 32'd1, {tag, " R6 valid"});
            check(rdata, exp, {tag, (exp == 32'd1023) ? " R7" : " R6"});
            last_ack = int'(rdata);
        end
        check(32'(irq), 32'(model_irq()), {tag, " R10"});
    endtask

    task automatic drain_all(input string tag, input bit use_clr);
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 17; k++) begin
                do_op(2, c, 32'd0, tag);
                if (last_ack == 1023) break;
            end
            if (use_clr) do_op(4, c, 32'h0000_FFFF, "R9");
            else for (int i = 0; i < 16; i++) if (ma[c][i]) do_op(3, c, 32'(i), "R8");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(32'(irq), 32'd0, "R11 irq");
        check(rdata, 32'd0, "R11 rdata");
        check(32'(rvalid), 32'd0, "R11 valid");

        // sweep: every writer against every filter
        for (int w = 0; w < NC; w++) begin
            for (int f = 0; f < 4; f++) begin
                string tg;
                int id;
                logic [7:0] lst;
                tg  = (f == 0) ? "R1" : (f == 1) ? "R3" : (f == 2) ? "R2" : "R4";
                id  = (w * 5 + f * 3) % 16;
                lst = 8'hA5 ^ 8'(w << 1);
                do_op(1, w, {6'd0, 2'(f), lst, 12'd0, 4'(id)}, {tg, " R5"});
                do_op(1, w, {6'd0, 2'(f), lst, 12'd0, 4'((id + 7) % 16)}, {tg, " R5"});
                drain_all(tg, (w + f) % 2 == 0);
            end
        end

        // list naming only nonexistent CPUs
        do_op(1, 1, {6'd0, 2'd0, 8'hF0, 12'd0, 4'd6}, "R1 high list");
        check(32'(irq), 32'd0, "R1 no target");

        // ordering: lowest number first
        do_op(1, 3, {6'd0, 2'd0, 8'h02, 12'd0, 4'd9},  "R5");
        do_op(1, 3, {6'd0, 2'd0, 8'h02, 12'd0, 4'd2},  "R5");
        do_op(1, 2, {6'd0, 2'd0, 8'h02, 12'd0, 4'd12}, "R5");
        drain_all("R6 order", 1'b0);

        // source overwrite
        do_op(1, 0, {6'd0, 2'd0, 8'h02, 12'd0, 4'd4}, "R5");
        do_op(1, 3, {6'd0, 2'd0, 8'h02, 12'd0, 4'd4}, "R5");
        do_op(2, 1, 32'd0, "R5 overwrite");
        check(rdata, 32'd4 | (32'd3 << 10), "R5 latest source");
        do_op(3, 1, 32'd4, "R8");

        // hold-off while active, EOI of out-of-range number
        do_op(1, 0, {6'd0, 2'd2, 8'd0, 12'd0, 4'd5}, "R2");
        do_op(2, 0, 32'd0, "R6");
        do_op(1, 0, {6'd0, 2'd2, 8'd0, 12'd0, 4'd5}, "R10 holdoff");
        check(32'(irq[0]), 32'd0, "R10 held while active");
        do_op(2, 0, 32'd0, "R7 while active");
        do_op(3, 0, 32'd21, "R8 out of range");
        check(32'(irq[0]), 32'd0, "R8 out of range no effect");
        do_op(3, 0, 32'd5, "R8");
        check(32'(irq[0]), 32'd1, "R8 redelivery");
        do_op(2, 0, 32'd0, "R6 redelivered");
        check(rdata, 32'd5, "R6 self source 0");

        // clear-active by another CPU has no effect
        do_op(1, 2, {6'd0, 2'd2, 8'd0, 12'd0, 4'd7}, "R2");
        do_op(2, 2, 32'd0, "R6");
        do_op(1, 2, {6'd0, 2'd2, 8'd0, 12'd0, 4'd7}, "R9");
        do_op(4, 1, 32'h0000_0080, "R9 other cpu");
        check(32'(irq[2]), 32'd0, "R9 other cpu keeps active");
        do_op(4, 2, 32'h0000_0080, "R9 own cpu");
        check(32'(irq[2]), 32'd1, "R9 own clear releases");
        drain_all("R9 tail", 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule